// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs single clause 22 management transactions on an MDC/MDIO pair on behalf of software that only sees a small register interface. Software places the outgoing value in a write-data register when it needs one. It then writes a 16-bit command word that names the operation, the PHY address and the register number. The controller builds the whole 64-bit management frame. It clocks the frame out on MDC, which is divided down from the system clock. For reads, it releases the data line and shifts in the PHY's reply.

The request bit that started a transaction stays visible in the command register until the last MDC cycle of the frame ends, and then clears. Software polls that bit. Once a read has finished, the 16-bit reply sits in a read-data register until the next read replaces it. A command write that arrives while a frame is on the wire is dropped completely.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_o` and `rd_data_o` read 0, and MDC, the MDIO output enable and every request bit are low.
- R2: Command word layout: bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 hold the register number. A command write made while idle always stores the full word. If neither request bit is set, no frame starts and MDC stays low.
- R3: MDC is low while idle. During a frame it starts low and toggles every `DIV_HALF` system clocks, giving 64 full MDC periods per frame.
- R4: The frame, sent MSB first, is 32 ones, start code 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register number, 2 turnaround bits and 16 data bits. MDIO changes only on a falling MDC edge.
- R5: A write frame sends turnaround 10 and then the write-data register value held when the command was accepted. Updating the write-data register during the frame does not change the bits on the wire.
- R6: In a read frame the output enable goes low from the first turnaround bit (bit 46) to the end of the frame. MDIO is sampled on the 16 rising MDC edges of the data phase. `rd_data_o` takes the sampled value in the cycle the request bit clears.
- R7: The request bits clear exactly 128·`DIV_HALF` clocks after the command is accepted. All other command bits keep their value.
- R8: A command write while a request bit is set is ignored, and that includes the cycle in which the frame completes. The next command is accepted in the cycle that follows completion.
- R9: When both request bits are set, the controller runs a write frame and clears both bits on completion.
- R10: A write frame leaves `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the command register, 1 selects the write-data register |
| reg_wdata_i | input | 16 | Register write value |
| cmd_o | output | 16 | Current command register, including the live request bits |
| rd_data_o | output | 16 | Value captured by the last completed read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe_o | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Frame completion and a new command write can land in the same clock. In that cycle the request bit clears, and a read also loads the read-data register, while the incoming command must still be treated as a write during busy. The bench waits for the reference model's last cycle of a read frame and presents a command write exactly at that edge. It expects the write to be discarded, the captured reply to appear, and the next command to be accepted one cycle later. The behavioural model compares MDC, the MDIO enable and data, and both registers on every clock across the whole sequence.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int WR_BIT    = 14;
  localparam int RD_BIT    = 13;
  localparam int PHY_LSB   = 8;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic [PRE_LEN-1:0] pre;
    logic [1:0]         st;
    logic [1:0]         op;
    logic [ADDR_W-1:0]  phy;
    logic [ADDR_W-1:0]  regad;
    logic [1:0]         ta;
    logic [DATA_W-1:0]  data;
  } mdio_frame_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              is_wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wd
  );
    mdio_frame_t f;
    f.pre   = '1;
    f.st    = 2'b01;
    f.op    = is_wr ? OP_WRITE : OP_READ;
    f.phy   = phy;
    f.regad = regad;
    f.ta    = is_wr ? 2'b10 : 2'b11;
    f.data  = is_wr ? wd : '0;
    return f;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == DW'(DIV_HALF - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 rd_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic [DATA_W-1:0]    cap_o
);
  logic [CNT_W-1:0]     bit_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic                 rd_q;
  logic                 busy_q;
  logic [DATA_W-1:0]    cap_q;
  logic                 last;
  logic                 released;

  assign last      = (bit_q == CNT_W'(FRAME_LEN - 1));
  assign released  = rd_q && (bit_q >= CNT_W'(TA_POS));
  assign done_o    = busy_q && fall_i && last;
  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_q && !released;
  assign cap_o     = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      cap_q  <= '0;
    end else if (start_i) begin
      bit_q  <= '0;
      sh_q   <= frame_i;
      rd_q   <= rd_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      // sample on MDC rise during read data phase
      if (rise_i && rd_q && (bit_q >= CNT_W'(DATA_POS)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [DATA_W-1:0]    cmd_q;
  logic [DATA_W-1:0]    wd_q;
  logic [DATA_W-1:0]    rdd_q;
  logic                 busy;
  logic                 done;
  logic                 rise;
  logic                 fall;
  logic [DATA_W-1:0]    cap;
  logic                 cmd_wr;
  logic                 req_wr;
  logic                 req_rd;
  logic                 start;
  logic [FRAME_LEN-1:0] frame;

  assign cmd_wr = reg_we_i && !reg_sel_i && !busy;
  assign req_wr = reg_wdata_i[WR_BIT];
  assign req_rd = reg_wdata_i[RD_BIT];
  assign start  = cmd_wr && (req_wr || req_rd);
  // write request wins when both are set
  assign frame  = build_frame(req_wr, reg_wdata_i[PHY_LSB +: ADDR_W],
                              reg_wdata_i[ADDR_W-1:0], wd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      wd_q  <= '0;
      rdd_q <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_q <= reg_wdata_i;
      end else if (done) begin
        cmd_q[WR_BIT] <= 1'b0;
        cmd_q[RD_BIT] <= 1'b0;
      end
      if (reg_we_i && reg_sel_i) wd_q <= reg_wdata_i;
      if (done && !cmd_q[WR_BIT]) rdd_q <= cap;
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (frame),
    .rd_i      (!req_wr),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .cap_o     (cap)
  );

  assign cmd_o     = cmd_q;
  assign rd_data_o = rdd_q;
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cmd_o,
  input logic [15:0] rd_data_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  logic req;
  assign req = cmd_o[14] | cmd_o[13];

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |-> (!mdc_o && !mdio_oe_o));

  assert_mdc_only_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> req);

  assert_mdio_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mdio_oe_o) && mdio_oe_o && !$fell(mdc_o)) |-> $stable(mdio_o));

  assert_cmd_held_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> ((cmd_o & 16'h9FFF) == ($past(cmd_o) & 16'h9FFF)));

  assert_rdata_on_read_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(cmd_o[13]) |-> $stable(rd_data_o));

  assert_write_keeps_rdata_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_o[14]) |-> $stable(rd_data_o));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_o     (cmd_o),
  .rd_data_o (rd_data_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_cmd_ctrl_test.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_test;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] cmd_o, rd_o;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_en = 0;

  // reference model state
  bit          m_busy = 0;
  int          m_k = 0;
  bit          m_isrd = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_cmd = '0, m_wd = '0, m_rd = '0;
  logic [15:0] phy_val = '0;

  always #10 clk = ~clk;

  mdio_cmd_ctrl #(.DIV_HALF(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .cmd_o(cmd_o), .rd_data_o(rd_o), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk_frame(input logic [15:0] c, input logic [15:0] d);
    bit w;
    w = c[14];
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), c[12:8], c[4:0],
            (w ? 2'b10 : 2'b11), (w ? d : 16'h0000)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_cmd = '0; m_wd = '0; m_rd = '0; m_isrd = 0;
    end else begin
      bit acc;
      logic [63:0] fr;
      acc = we && !sel && !m_busy && (wdata[14] || wdata[13]);
      fr  = mk_frame(wdata, m_wd);
      if (we && !sel && !m_busy) m_cmd = wdata;
      if (we && sel) m_wd = wdata;
      if (m_busy) begin
        m_k++;
        if (m_k == FRAME_CYC) begin
          m_busy = 0;
          if (m_isrd) m_rd = phy_val;
          m_cmd[14] = 1'b0;
          m_cmd[13] = 1'b0;
        end
      end
      if (acc) begin
        m_busy = 1; m_k = 0; m_frame = fr; m_isrd = !wdata[14];
      end
    end
  end

  // PHY model and per-cycle comparison
  always @(negedge clk) begin
    int idx;
    idx = m_k / (2 * HALF);
    mdio_in = (m_busy && m_isrd && idx >= 48) ? phy_val[63 - idx] : 1'b1;
    if (rst_n && cmp_en) begin
      bit e_oe;
      e_oe = m_busy && !(m_isrd && idx >= 46);
      chk("R3 mdc", {15'd0, mdc}, {15'd0, m_busy ? 1'b1 & ((m_k / HALF) % 2 == 1) : 1'b0});
      chk("R6 oe", {15'd0, mdio_oe}, {15'd0, e_oe});
      if (e_oe) chk("R4 mdio", {15'd0, mdio_out}, {15'd0, m_frame[63 - idx]});
      chk("R7 cmd", cmd_o, m_cmd);
      chk("R6 rd_data", rd_o, m_rd);
    end
  end

  task automatic wr(input bit s, input logic [15:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd", cmd_o, 16'h0000);
    chk("R1 rd", rd_o, 16'h0000);
    chk("R1 mdc/oe", {14'd0, mdc, mdio_oe}, 16'h0000);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);

    // write frame, phy 5 reg 0x11; later data update and command must not matter
    wr(1'b1, 16'hA5C3);
    wr(1'b0, 16'h4511);
    repeat (20) @(negedge clk);
    wr(1'b1, 16'h1234);   // R5
    wr(1'b0, 16'h2000);   // R8
    chk("R8 cmd held", cmd_o, 16'h4511);
    wait_idle();
    chk("R7 cleared", cmd_o, 16'h0511);

    // read phy 0x1F reg 0
    phy_val = 16'hBEEF;
    wr(1'b0, 16'h3F00);
    wait_idle();
    chk("R6 read value", rd_o, 16'hBEEF);

    // read phy 0 reg 0x1F, command collides with completion cycle
    phy_val = 16'h4321;
    wr(1'b0, 16'h201F);
    while (!(m_busy && m_k == FRAME_CYC - 1)) @(negedge clk);
    wr(1'b0, 16'h4C01);   // R8 collision, dropped
    chk("R8 collision dropped", cmd_o, 16'h001F);
    chk("R6 collision read", rd_o, 16'h4321);

    // next cycle accepted: both request bits -> write frame
    wr(1'b1, 16'h0F0F);
    wr(1'b0, 16'h6A0C);
    chk("R9 busy", cmd_o, 16'h6A0C);
    wait_idle();
    chk("R9 both cleared", cmd_o, 16'h0A0C);
    chk("R10 rd kept", rd_o, 16'h4321);

    // no request bits: stored, no frame
    wr(1'b0, 16'h0A0B);
    repeat (10) @(negedge clk);
    chk("R2 stored", cmd_o, 16'h0A0B);
    chk("R2 no mdc", {15'd0, mdc}, 16'h0000);

    // write frame with all-ones address fields
    wr(1'b1, 16'h8001);
    wr(1'b0, 16'h5F1F);
    wait_idle();
    chk("R2 field layout", cmd_o, 16'h1F1F);
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule